// File: doc/BRIEF.md
# One-Time-Programmable Configuration Bank with Burn Lock

The block holds four 8-bit registers: configuration words 0 to 2 and a user word 3. Each one has a writable RAM shadow and a fuse copy, and the fuse copy is modelled as a sticky register. A serial command decoder upstream writes the shadows and can issue a single program command. That command waits for the programming-voltage indication and then burns the whole bank over a fixed number of cycles. The last step sets a lock bit, and the block then answers with a one-cycle handshake. From then on the outputs come from the fuses, every write path is closed, and an even-parity monitor watches the programmed bank.

The lock bit is bit `LOCK_BIT` (default 7) of word 2. The stored parity bit is bit `PAR_BIT` (default 6) of word 2. The bank is presented on `cfg_word` with word i at bits [8i+7:8i].

The sequencer has these states:
- `ST_IDLE`: shadows writable.
- `ST_WAIT_SUPPLY`: waiting for the supply.
- `ST_BURN`: timed copy.
- `ST_SEAL`: lock bit burn.
- `ST_HANDSHAKE`: response pulse.
- `ST_LOCKED`: final.

Its transitions are:
- IDLE to WAIT_SUPPLY on a program command.
- IDLE to LOCKED when the lock fuse reads 1.
- WAIT_SUPPLY to BURN when the supply is good.
- BURN to SEAL on the last count.
- SEAL to HANDSHAKE.
- HANDSHAKE to LOCKED.
- LOCKED stays where it is.

Top module: `otp_cfg_lock`

## Requirements
- R1: After reset, `cfg_word` is all zero and `locked`, `busy`, `done` and `parity_err` are 0.
- R2: Before locking, a write with `wr_en` in the idle state stores `wr_data` into word `wr_addr`, visible on `cfg_word` one cycle later. The lock bit position (bit 7 of word 2) always reads 0 from the shadow.
- R3: After a program command, while `vpp_good` is low the block stays busy, raises no `done` and burns nothing.
- R4: `busy` is high for K + BURN_CYCLES + 2 cycles, where K is the number of sampled cycles spent waiting with `vpp_good` low.
- R5: At the end, all four words are copied from the shadows into the fuses, including words never written, which burn as zero. The lock bit is then set, and `done` pulses for exactly one cycle, in the same cycle that `locked` first reads 1.
- R6: Writes and program commands during the busy period, during the handshake, or after locking are ignored. Once locked, `cfg_word` shows the fuse copy and never changes.
- R7: With `locked` = 1 and `cfg_mode` = 0, `parity_err` is 1 one cycle after the XOR of all 32 fuse bits (lock and parity bit included) is 1, and 0 when it is 0.
- R8: `parity_err` is 0 in the cycle after any cycle with `cfg_mode` = 1.
- R9: A write and a program command given in the same idle cycle both take effect, and the written value is the one burned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | 1 = configuration mode (parity error suppressed) |
| wr_en | input | 1 | Shadow write strobe |
| wr_addr | input | 2 | Word index, 0..2 configuration, 3 user |
| wr_data | input | 8 | Write data |
| prog_req | input | 1 | Program command |
| vpp_good | input | 1 | Programming supply adequate |
| cfg_word | output | 32 | Selected copy of all four words |
| locked | output | 1 | Lock fuse state |
| busy | output | 1 | Waiting or burning |
| done | output | 1 | One-cycle handshake after the burn |
| parity_err | output | 1 | Fuse bank parity error |

## Verification
Two functions can coincide in one cycle.

The first is a shadow write landing in the same idle cycle as the program command. The bench provokes it in directed and random trials and judges it by whether the burned word 2 carries that last write.

The second is a write or a fresh program command arriving in the lock-burn cycle or the handshake cycle. The bench aims stimulus at the exact cycle indices computed from K and BURN_CYCLES, then confirms that the fused contents equal the model and that no second busy period follows.

// File: rtl/otp_cfg_pkg.sv
package otp_cfg_pkg;
    localparam int unsigned CU_W     = 8;
    localparam int unsigned CU_REGS  = 4;
    localparam int unsigned CU_AW    = $clog2(CU_REGS);
    localparam int unsigned SEAL_REG = 2;
    localparam int unsigned BANK_W   = CU_W * CU_REGS;

    typedef logic [CU_W-1:0] cu_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SUPPLY,
        ST_BURN,
        ST_SEAL,
        ST_HANDSHAKE,
        ST_LOCKED
    } seq_state_e;
endpackage

// File: rtl/otp_cfg_seq.sv
module otp_cfg_seq
    import otp_cfg_pkg::*;
#(
    parameter int unsigned BURN_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_req,
    input  logic vpp_good,
    input  logic lock_in,
    output logic wr_ok,
    output logic fuse_copy,
    output logic fuse_seal,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = $clog2(BURN_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(BURN_CYCLES - 1);

    seq_state_e st_q, st_d;
    logic [CW-1:0] cnt_q;

    // state register and burn timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == ST_BURN) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (lock_in)       st_d = ST_LOCKED;
                else if (prog_req) st_d = ST_WAIT_SUPPLY;
            end
            ST_WAIT_SUPPLY: if (vpp_good) st_d = ST_BURN;
            ST_BURN:        if (cnt_q == LAST) st_d = ST_SEAL;
            ST_SEAL:        st_d = ST_HANDSHAKE;
            ST_HANDSHAKE:   st_d = ST_LOCKED;
            ST_LOCKED:      st_d = ST_LOCKED;
            default:        st_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        wr_ok     = (st_q == ST_IDLE) && !lock_in;
        fuse_copy = (st_q == ST_BURN) && (cnt_q == LAST);
        fuse_seal = (st_q == ST_SEAL);
        busy      = (st_q == ST_WAIT_SUPPLY) || (st_q == ST_BURN) || (st_q == ST_SEAL);
        done      = (st_q == ST_HANDSHAKE);
    end

    a_r3_hold_without_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_SUPPLY && !vpp_good) |=> (st_q == ST_WAIT_SUPPLY && !done && !fuse_copy));
    a_r4_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BURN) |-> (cnt_q <= LAST));
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_seal_follows_copy: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_copy |=> fuse_seal);
    a_r6_final_state: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOCKED) |=> (st_q == ST_LOCKED && !busy));
endmodule

// File: rtl/otp_cfg_bank.sv
module otp_cfg_bank
    import otp_cfg_pkg::*;
#(
    parameter int unsigned LOCK_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic              wr_en,
    input  logic [CU_AW-1:0]  wr_addr,
    input  cu_word_t          wr_data,
    input  logic              fuse_copy,
    input  logic              fuse_seal,
    output logic [BANK_W-1:0] cfg_word,
    output logic [BANK_W-1:0] fuse_flat,
    output logic              lock
);
    localparam int unsigned LOCK_IDX = SEAL_REG * CU_W + LOCK_BIT;

    logic [BANK_W-1:0] ram_flat;

    assign lock = fuse_flat[LOCK_IDX];

    for (genvar g = 0; g < CU_REGS; g++) begin : g_word
        localparam cu_word_t KEEP = (g == SEAL_REG) ? ~(cu_word_t'(1) << LOCK_BIT) : '1;
        localparam cu_word_t SEAL = (g == SEAL_REG) ?  (cu_word_t'(1) << LOCK_BIT) : '0;

        cu_word_t ram_q;
        cu_word_t fuse_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ram_q  <= '0;
                fuse_q <= '0;
            end else begin
                if (wr_ok && wr_en && (wr_addr == CU_AW'(g)))
                    ram_q <= wr_data & KEEP;
                if (fuse_copy && !lock)
                    fuse_q <= ram_q;
                else if (fuse_seal && !lock)
                    fuse_q <= fuse_q | SEAL;
            end
        end

        assign ram_flat[g*CU_W +: CU_W]  = ram_q;
        assign fuse_flat[g*CU_W +: CU_W] = fuse_q;
        assign cfg_word[g*CU_W +: CU_W]  = lock ? fuse_q : ram_q;
    end

    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);
    a_r6_fuses_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(fuse_flat));
    a_r6_shadow_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(ram_flat));
    a_r2_lock_not_writable: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |-> !cfg_word[LOCK_IDX]);
endmodule

// File: rtl/otp_cfg_parity.sv
module otp_cfg_parity
    import otp_cfg_pkg::*;
#(
    parameter int unsigned PAR_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] fuse_flat,
    input  logic              lock,
    input  logic              cfg_mode,
    output logic              parity_err
);
    localparam int unsigned PAR_IDX = SEAL_REG * CU_W + PAR_BIT;
    localparam logic [BANK_W-1:0] DATA_MASK = ~({{(BANK_W-1){1'b0}}, 1'b1} << PAR_IDX);

    logic computed, stored, differs;

    assign computed = ^(fuse_flat & DATA_MASK);
    assign stored   = fuse_flat[PAR_IDX];
    assign differs  = computed != stored;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) parity_err <= 1'b0;
        else        parity_err <= lock && !cfg_mode && differs;
    end

    a_r8_cfg_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |=> !parity_err);
    a_r7_odd_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !cfg_mode && (^fuse_flat)) |=> parity_err);
    a_r7_even_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(^fuse_flat) |=> !parity_err);
endmodule

// File: rtl/otp_cfg_lock.sv
module otp_cfg_lock
    import otp_cfg_pkg::*;
#(
    parameter int unsigned BURN_CYCLES = 32,
    parameter int unsigned PAR_BIT     = 6,
    parameter int unsigned LOCK_BIT    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              wr_en,
    input  logic [CU_AW-1:0]  wr_addr,
    input  logic [CU_W-1:0]   wr_data,
    input  logic              prog_req,
    input  logic              vpp_good,
    output logic [BANK_W-1:0] cfg_word,
    output logic              locked,
    output logic              busy,
    output logic              done,
    output logic              parity_err
);
    logic              wr_ok, fuse_copy, fuse_seal;
    logic [BANK_W-1:0] fuse_flat;

    otp_cfg_seq #(.BURN_CYCLES(BURN_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_req  (prog_req),
        .vpp_good  (vpp_good),
        .lock_in   (locked),
        .wr_ok     (wr_ok),
        .fuse_copy (fuse_copy),
        .fuse_seal (fuse_seal),
        .busy      (busy),
        .done      (done)
    );

    otp_cfg_bank #(.LOCK_BIT(LOCK_BIT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (wr_ok),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fuse_copy (fuse_copy),
        .fuse_seal (fuse_seal),
        .cfg_word  (cfg_word),
        .fuse_flat (fuse_flat),
        .lock      (locked)
    );

    otp_cfg_parity #(.PAR_BIT(PAR_BIT)) u_parity (
        .clk        (clk),
        .rst_n      (rst_n),
        .fuse_flat  (fuse_flat),
        .lock       (locked),
        .cfg_mode   (cfg_mode),
        .parity_err (parity_err)
    );

    a_r5_handshake_with_lock: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (locked && !busy));
endmodule

// File: tb/test_otp_cfg_lock.sv
module test_otp_cfg_lock;
    localparam int B = 32;

    logic        clk = 1'b0, rst_n = 1'b0, cfg_mode = 1'b0;
    logic        wr_en = 1'b0, prog_req = 1'b0, vpp_good = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [31:0] cfg_word;
    logic        locked, busy, done, parity_err;

    int compared = 0, mismatched = 0;
    bit finished = 0;
    logic [7:0] m [4];

    always #2.5 clk = ~clk; // 200 MHz with a 1 ns unit

    otp_cfg_lock #(.BURN_CYCLES(B), .PAR_BIT(6), .LOCK_BIT(7)) i_otp_cfg_lock (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .prog_req(prog_req),
        .vpp_good(vpp_good), .cfg_word(cfg_word), .locked(locked),
        .busy(busy), .done(done), .parity_err(parity_err)
    );

    function automatic logic [31:0] expect_bank(input bit lk);
        return {m[3], (lk ? (m[2] | 8'h80) : m[2]), m[1], m[0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_mode = 1'b0; wr_en = 1'b0; prog_req = 1'b0; vpp_good = 1'b0;
        for (int i = 0; i < 4; i++) m[i] = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 bank after reset", cfg_word, 32'h0);
        chk("R1 flags after reset", {28'h0, locked, busy, done, parity_err}, 32'h0);
    endtask

    task automatic write_word(input logic [1:0] a, input logic [7:0] d, input bit with_prog);
        wr_en = 1'b1; wr_addr = a; wr_data = d; prog_req = with_prog;
        tick();
        wr_en = 1'b0; prog_req = 1'b0;
        m[a] = (a == 2'd2) ? (d & 8'h7f) : d;
        chk(with_prog ? "R9 write with program visible" : "R2 shadow write", cfg_word, expect_bank(0));
    endtask

    task automatic run_trial(input bit bad_par, input bit collide, input int k, input bit no_writes);
        logic [7:0] d2;
        logic       p, exp_par;
        int         busy_n;
        bit         seen, lk_prev;
        do_reset();
        if (!no_writes) begin
            for (int a = 0; a < 4; a++)
                if (a != 2 && ($urandom % 4) != 0) write_word(a[1:0], 8'($urandom), 1'b0);
            d2 = 8'($urandom);
            p  = (^m[0]) ^ (^m[1]) ^ (^m[3]) ^ (^(d2 & 8'h3f)) ^ 1'b1;
            d2[6] = p ^ bad_par;
            d2[7] = 1'b1; // lock position must be dropped (R2)
            write_word(2'd2, d2, collide);
        end
        if (no_writes || !collide) begin
            prog_req = 1'b1;
            tick();
            prog_req = 1'b0;
        end
        busy_n = 0; seen = 0; lk_prev = locked;
        for (int i = 0; i < k + B + 10 && !seen; i++) begin
            if (busy) busy_n++;
            if (i <= k) chk("R3 waiting for supply", {30'h0, busy, done}, 32'h2);
            if (done) begin
                seen = 1;
                chk("R5 lock rises with handshake", {30'h0, lk_prev, locked}, 32'h1);
            end
            lk_prev = locked;
            wr_en = 1'b0; prog_req = 1'b0;
            if (i == k) vpp_good = 1'b1;
            if (i == 1 || i == k + B + 1 || i == k + B + 2) begin
                wr_en = 1'b1; wr_addr = 2'($urandom); wr_data = 8'($urandom);
                prog_req = (i == k + B + 2);
            end
            tick();
        end
        wr_en = 1'b0; prog_req = 1'b0;
        chk("R4 busy length", busy_n, k + B + 2);
        chk("R5 handshake seen", {31'h0, seen}, 32'h1);
        chk("R5 locked", {31'h0, locked}, 32'h1);
        vpp_good = 1'b0;
        prog_req = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = ~m[0];
        tick();
        prog_req = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R6 no second burn", {30'h0, busy, done}, 32'h0);
            tick();
        end
        chk("R6 fused contents", cfg_word, expect_bank(1));
        if (collide && !no_writes)
            chk("R9 collided write burned", {24'h0, cfg_word[23:16]}, {24'h0, m[2] | 8'h80});
        exp_par = ^expect_bank(1);
        chk("R7 parity monitor", {31'h0, parity_err}, {31'h0, exp_par});
        cfg_mode = 1'b1;
        tick();
        chk("R8 suppressed in config mode", {31'h0, parity_err}, 32'h0);
        cfg_mode = 1'b0;
        tick();
        chk("R7 parity after mode return", {31'h0, parity_err}, {31'h0, exp_par});
    endtask

    initial begin
        void'($urandom(32'h0C0FFEE5));
        tick();
        run_trial(1'b0, 1'b0, 0, 1'b1); // nothing written: only lock set, odd
        run_trial(1'b0, 1'b1, 3, 1'b0); // write and program in one cycle
        run_trial(1'b1, 1'b0, 1, 1'b0); // wrong parity programmed
        for (int t = 0; t < 6; t++)
            run_trial(1'($urandom), 1'($urandom), int'($urandom % 6), 1'b0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule